// File: doc/BRIEF.md
# Nibble-to-PN-Chip DSSS Spreader

This block is the spreading stage of a low-rate 2.4 GHz direct-sequence transmitter. Frame octets arrive one at a time over a valid/ready handshake, starting with the first preamble octet and ending with the last payload octet. Each octet is split into two 4-bit data symbols, low nibble first. Each symbol is replaced by one of sixteen 32-chip pseudo-noise sequences, and those chips leave the block serially.

Chips advance on a chip-enable tick supplied by the surrounding clocking logic. That tick runs at 32 times the symbol rate, for example 2 Mchip/s. Between ticks every output holds its value. The block marks the final chip of each symbol. It also marks the final chip of the octet that the sender flagged as the end of the frame, so the I/Q splitter downstream can close the burst. The chip table is computed from constants inside the block.

Top module: `dsss_spreader`

## Requirements
- R1: After reset, `chip_valid`, `sym_last` and `frame_last` are low and `in_ready` is high.
- R2: An octet is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the 64th chip of that octet has been emitted. `in_ready` is high again on the cycle after that chip's tick.
- R3: Bits 3:0 of an octet form the first symbol and bits 7:4 form the second symbol.
- R4: Symbol 0, listed as chips c0 to c31, is 11011001110000110101001000101110. For symbol k from 1 to 7, chip ci equals chip c((i-4k) mod 32) of symbol 0. Symbol k+8 equals symbol k with every odd-indexed chip inverted.
- R5: Chip c0 of a symbol comes out first. Each chip-enable tick while an octet is held emits exactly one chip with `chip_valid` high, on the clock edge of the tick. Each symbol emits 32 chips.
- R6: On cycles without a chip-enable tick, `chip_out`, `chip_valid`, `sym_last` and `frame_last` keep their previous values.
- R7: `sym_last` is high exactly on chip c31 of each symbol.
- R8: `frame_last` is high only on chip c31 of the second symbol of an octet that was taken with `in_last` high.
- R9: A chip-enable tick while no octet is held drives `chip_valid`, `sym_last` and `frame_last` low.
- R10: An 11-octet frame produces 22 symbols and 704 chips in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Octet offered |
| in_ready | output | 1 | Block can take an octet |
| in_data | input | 8 | Octet to spread |
| in_last | input | 1 | Octet is the final one of the frame |
| chip_en | input | 1 | Chip-rate tick |
| chip_out | output | 1 | Current chip |
| chip_valid | output | 1 | `chip_out` carries a chip from the last tick |
| sym_last | output | 1 | Current chip closes a symbol |
| frame_last | output | 1 | Current chip closes the frame |

## Verification
The bench builds the block with its default widths: 8-bit octets, 4-bit symbols and 32 chips per symbol. These are the only values the chip table covers. The bench chooses the chip-enable spacing itself. With a tick on every cycle, the edge between one octet's last chip and the next handshake is reached. With a tick every third cycle, the hold cycles between ticks become observable. A full 11-octet frame whose octets cover all sixteen nibble values exercises every table entry and the frame total.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
    localparam int unsigned PN_LEN  = 32;
    localparam int unsigned PN_NSEQ = 16;

    // Base sequence, bit i holds chip ci.
    localparam logic [PN_LEN-1:0] PN_BASE    = 32'h744A_C39B;
    localparam logic [PN_LEN-1:0] PN_ODDMASK = 32'hAAAA_AAAA;

    function automatic logic [PN_LEN-1:0] pn_seq(input int unsigned k);
        int unsigned r;
        logic [PN_LEN-1:0] s;
        r = (k % 8) * 4;
        if (r == 0) s = PN_BASE;
        else        s = (PN_BASE << r) | (PN_BASE >> (PN_LEN - r));
        if (k >= 8) s = s ^ PN_ODDMASK;
        return s;
    endfunction
endpackage

// File: rtl/dsss_chip_rom.sv
module dsss_chip_rom #(
    parameter int unsigned SYM_W = 4,
    parameter int unsigned CHIPS = 32,
    localparam int unsigned NENT = 1 << SYM_W,
    localparam int unsigned IDX_W = $clog2(CHIPS)
) (
    input  logic [SYM_W-1:0] sym,
    input  logic [IDX_W-1:0] idx,
    output logic             chip
);
    logic [CHIPS-1:0] tab [NENT];

    for (genvar g = 0; g < NENT; g++) begin : g_tab
        assign tab[g] = CHIPS'(dsss_pkg::pn_seq(g));
    end

    assign chip = tab[sym][idx];
endmodule

// File: rtl/dsss_seq_ctrl.sv
module dsss_seq_ctrl #(
    parameter int unsigned OCT_W = 8,
    parameter int unsigned SYM_W = 4,
    parameter int unsigned CHIPS = 32,
    localparam int unsigned NSYM  = OCT_W / SYM_W,
    localparam int unsigned SEL_W = (NSYM > 1) ? $clog2(NSYM) : 1,
    localparam int unsigned IDX_W = $clog2(CHIPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_last,
    input  logic             chip_en,
    output logic [SYM_W-1:0] cur_sym,
    output logic [IDX_W-1:0] cur_idx,
    input  logic             rom_chip,
    output logic             chip_out,
    output logic             chip_valid,
    output logic             sym_last,
    output logic             frame_last
);
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(CHIPS - 1);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NSYM - 1);

    typedef struct packed {
        logic                       busy;
        logic [NSYM-1:0][SYM_W-1:0] octet;
        logic [SEL_W-1:0]           sel;
        logic [IDX_W-1:0]           idx;
        logic                       last_oct;
        logic                       chip;
        logic                       vld;
        logic                       slast;
        logic                       flast;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.busy;
        cur_sym  = st_q.octet[st_q.sel];
        cur_idx  = st_q.idx;

        if (!st_q.busy && in_valid) begin
            st_d.busy     = 1'b1;
            st_d.octet    = in_data;
            st_d.sel      = '0;
            st_d.idx      = '0;
            st_d.last_oct = in_last;
        end

        if (chip_en) begin
            if (st_q.busy) begin
                st_d.chip  = rom_chip;
                st_d.vld   = 1'b1;
                st_d.slast = (st_q.idx == IDX_MAX);
                st_d.flast = (st_q.idx == IDX_MAX) && (st_q.sel == SEL_MAX) && st_q.last_oct;
                if (st_q.idx == IDX_MAX) begin
                    st_d.idx = '0;
                    if (st_q.sel == SEL_MAX) st_d.busy = 1'b0;
                    else                     st_d.sel  = st_q.sel + 1'b1;
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end else begin
                st_d.vld   = 1'b0;
                st_d.slast = 1'b0;
                st_d.flast = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chip_out   = st_q.chip;
    assign chip_valid = st_q.vld;
    assign sym_last   = st_q.slast;
    assign frame_last = st_q.flast;

    // R2
    take_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R6
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> ($stable(chip_out) && $stable(chip_valid) &&
                      $stable(sym_last) && $stable(frame_last)));

    // R8
    frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last |-> (sym_last && chip_valid));

    // R9
    idle_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && in_ready) |=> !chip_valid);

    // R7
    sym_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_last |-> chip_valid);
endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader #(
    parameter int unsigned OCT_W = 8,
    parameter int unsigned SYM_W = 4,
    parameter int unsigned CHIPS = 32,
    localparam int unsigned IDX_W = $clog2(CHIPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [OCT_W-1:0] in_data,
    input  logic             in_last,
    input  logic             chip_en,
    output logic             chip_out,
    output logic             chip_valid,
    output logic             sym_last,
    output logic             frame_last
);
    logic [SYM_W-1:0] cur_sym;
    logic [IDX_W-1:0] cur_idx;
    logic             rom_chip;

    dsss_chip_rom #(.SYM_W(SYM_W), .CHIPS(CHIPS)) u_rom (
        .sym  (cur_sym),
        .idx  (cur_idx),
        .chip (rom_chip)
    );

    dsss_seq_ctrl #(.OCT_W(OCT_W), .SYM_W(SYM_W), .CHIPS(CHIPS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_last    (in_last),
        .chip_en    (chip_en),
        .cur_sym    (cur_sym),
        .cur_idx    (cur_idx),
        .rom_chip   (rom_chip),
        .chip_out   (chip_out),
        .chip_valid (chip_valid),
        .sym_last   (sym_last),
        .frame_last (frame_last)
    );
endmodule

// File: tb/dsss_spreader_tb.sv
module dsss_spreader_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [7:0] in_data = '0;
    logic in_last = 1'b0;
    logic chip_en = 1'b0;
    logic chip_out, chip_valid, sym_last, frame_last;

    int checks = 0;
    int fails = 0;
    int en_period = 0;
    int chip_total = 0;
    int flast_total = 0;
    logic en_prev = 1'b0;
    logic have_prev = 1'b0;
    logic [3:0] prev_out = '0;
    logic [2:0] expq [$];

    // Symbol 0 written c0 first: chip ci is bit (31-i).
    localparam logic [31:0] SYM0 = 32'b11011001110000110101001000101110;

    always #10 clk = ~clk;

    dsss_spreader u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .chip_en(chip_en),
        .chip_out(chip_out), .chip_valid(chip_valid),
        .sym_last(sym_last), .frame_last(frame_last)
    );

    function automatic logic exp_chip(input int sym, input int i);
        int j;
        logic c;
        j = (i - 4 * (sym % 8) + 64) % 32;
        c = SYM0[31 - j];
        if (sym >= 8 && (i % 2) == 1) c = ~c;
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_octet(input logic [7:0] d, input logic last);
        int s;
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_last  = last;
        for (int n = 0; n < 2; n++) begin
            s = (n == 0) ? int'(d[3:0]) : int'(d[7:4]);   // R3 low nibble first
            for (int i = 0; i < 32; i++)
                expq.push_back({exp_chip(s, i), i == 31, (i == 31) && (n == 1) && last});
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 in_ready after take", {31'b0, in_ready}, 32'd0);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (en_period > 0) chip_en = ($time / 20) % en_period == 0;
            else               chip_en = 1'b0;
        end
    end

    always @(posedge clk) en_prev <= chip_en;

    always @(negedge clk) begin
        logic [2:0] e;
        if (rst_n) begin
            if (en_prev && chip_valid) begin
                chip_total++;
                if (frame_last) flast_total++;
                if (expq.size() == 0) begin
                    check("R5 unexpected chip", 32'd1, 32'd0);
                end else begin
                    e = expq.pop_front();
                    check("R4/R5 chip value", {31'b0, chip_out}, {31'b0, e[2]});
                    check("R7 sym_last", {31'b0, sym_last}, {31'b0, e[1]});
                    check("R8 frame_last", {31'b0, frame_last}, {31'b0, e[0]});
                end
            end else if (!en_prev && have_prev) begin
                check("R6 hold", {28'b0, chip_out, chip_valid, sym_last, frame_last},
                      {28'b0, prev_out});
            end
            prev_out  = {chip_out, chip_valid, sym_last, frame_last};
            have_prev = 1'b1;
        end
    end

    initial begin
        logic [7:0] frame [11];
        frame = '{8'h10, 8'h32, 8'h54, 8'h76, 8'h98, 8'hBA,
                  8'hDC, 8'hFE, 8'h0F, 8'hA7, 8'h3C};
        repeat (3) @(negedge clk);
        check("R1 chip_valid", {31'b0, chip_valid}, 32'd0);
        check("R1 sym_last", {31'b0, sym_last}, 32'd0);
        check("R1 frame_last", {31'b0, frame_last}, 32'd0);
        check("R1 in_ready", {31'b0, in_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5: one octet, tick every cycle, back to back octets
        en_period = 1;
        send_octet(8'hA5, 1'b0);
        send_octet(8'h3C, 1'b1);
        while (expq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        check("R2 ready after octet", {31'b0, in_ready}, 32'd1);

        // R9: tick with nothing held
        @(negedge clk);
        check("R9 idle chip_valid", {31'b0, chip_valid}, 32'd0);
        check("R9 idle sym_last", {31'b0, sym_last}, 32'd0);

        // R10: full frame, sparse ticks
        chip_total  = 0;
        flast_total = 0;
        en_period   = 3;
        for (int k = 0; k < 11; k++) send_octet(frame[k], k == 10);
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R10 chip count", chip_total, 32'd704);
        check("R8 frame_last count", flast_total, 32'd1);
        check("R9 idle after frame", {31'b0, chip_valid}, 32'd0);

        en_period = 0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule